// File: doc/BRIEF.md
# General-Purpose Input Event Latch and Interrupt Router

This block watches a bank of general-purpose inputs. For each input it records whether an event happened, and it sends that event to one of two interrupt lines, or to neither. One line is the system-management interrupt and the other is the configuration interrupt. Each input first passes through a synchronizer. A sample strobe then qualifies the synchronized value. An input only counts as active when two strobes in a row see it at its selected active level. The strobe fires on every clock edge while the system runs. It follows an external slow tick while the system sleeps, so a slow-tick input stands in for the 32.768 kHz rate.

Every input except input 0 has a sticky status flag. The flag stays set after its input goes quiet, until software writes a one to that bit. A clear does not win over an input that is still active: the flag simply stays set, so the inputs behave as level-triggered sources. Input 0 has no latch. Its status bit and its routed interrupt follow the qualified level of the input directly. Software reaches three registers through a small register port that has a combinational read path.

Top module: `gpi_event_router`

## Requirements
- R1: After reset, all status bits read 0, the polarity register (address 1) reads 0, which means active-high, the routing register (address 2) reads 0, and both interrupt outputs are low.
- R2: Bits [2i+1:2i] of the routing register at address 2 select the target for input i. Code 01 selects the management interrupt and code 10 selects the configuration interrupt. Codes 00 and 11 select neither, so one input can never drive both lines. The register reads back what was written.
- R3: Each interrupt output is high exactly while at least one status bit routed to it is set. It stays high for as long as such a bit remains set.
- R4: A status bit sets only when its input was at the active level on two consecutive sample strobes. An input that is active on only one strobe leaves its bit unchanged.
- R5: Bits 1 to NUM_IN-1 of the status register at address 0 are sticky. Once set, a bit stays 1 after its input returns to the inactive level.
- R6: Writing to address 0 clears each status bit whose write-data bit is 1. The clear takes effect at the write edge. Write-data bits that are 0 leave the status unchanged.
- R7: If the input is still qualified as active when its bit is written with a 1, the bit stays 1. Setting takes priority over clearing, and no new edge is needed to set the bit again.
- R8: Bit i of the polarity register at address 1 set to 1 makes input i active-low. The status bit then sets 3 clock edges after the write edge when the pin is held low.
- R9: While running, a sticky status bit and its routed interrupt change on the 5th rising clock edge after the input changes.
- R10: Input 0 has no latch. Status bit 0 and its routed interrupt rise on the 4th edge after the input rises, and fall on the 3rd edge after it falls. Writing a 1 to bit 0 at address 0 has no effect.
- R11: While `sleep_i` is high, inputs are sampled only on cycles where `slow_tick_i` is high. An input that is active for less than one tick period never sets its bit. An input held across several ticks does set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | High selects slow-tick sampling |
| slow_tick_i | input | 1 | One-cycle strobe at the slow sampling rate |
| gpi_i | input | NUM_IN | Asynchronous general-purpose inputs |
| reg_addr_i | input | 2 | Register address: 0 status, 1 polarity, 2 routing |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 2*NUM_IN | Register write data |
| reg_rdata_o | output | 2*NUM_IN | Register read data, combinational |
| irq_mgmt_o | output | 1 | Management interrupt |
| irq_cfg_o | output | 1 | Configuration interrupt |

## Verification
Each result has a fixed due cycle after its stimulus. A sticky bit and its interrupt are due on the 5th edge after an input changes. The live bit 0 is due on the 4th edge after a rise and the 3rd edge after a fall. A polarity write shows up 3 edges after its write edge, a clear shows up at the write edge itself, and a read is due in the same cycle. The driver queues every expected value together with its exact due cycle. It also checks the cycle just before the due cycle, so a result that arrives one edge early or one edge late is caught. Sleep-mode results depend on the tick phase, so those checks are taken only at settled points, well after the stimulus has ended.

// File: rtl/gpi_evt_pkg.sv
package gpi_evt_pkg;

   // per-input routing code, two bits each in the routing register
   typedef enum logic [1:0] {
      ROUTE_OFF  = 2'b00,
      ROUTE_MGMT = 2'b01,
      ROUTE_CFG  = 2'b10,
      ROUTE_RSVD = 2'b11
   } route_e;

   localparam logic [1:0] ADDR_STATUS = 2'd0;
   localparam logic [1:0] ADDR_LEVEL  = 2'd1;
   localparam logic [1:0] ADDR_ROUTE  = 2'd2;

endpackage

// File: rtl/gpi_strobe_gen.sv
module gpi_strobe_gen #(
   parameter int FAST_DIV = 1
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_i,
   input  logic slow_tick_i,
   output logic sample_en_o
);

   logic fast_tick;

   generate
      if (FAST_DIV < 1) begin : g_bad_div
         $error("gpi_strobe_gen: FAST_DIV must be at least 1");
      end

      if (FAST_DIV == 1) begin : g_every
         assign fast_tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(FAST_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FAST_DIV - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               div_q <= '0;
            end else if (div_q == DIV_LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end

         assign fast_tick = (div_q == DIV_LAST);
      end
   endgenerate

   assign sample_en_o = sleep_i ? slow_tick_i : fast_tick;

endmodule

// File: rtl/gpi_input_qual.sv
module gpi_input_qual #(
   parameter int NUM_IN      = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_IN-1:0] gpi_i,
   input  logic [NUM_IN-1:0] level_inv_i,
   input  logic              sample_en_i,
   output logic [NUM_IN-1:0] qual_o
);

   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpi_input_qual: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_IN-1:0] sync_q [SYNC_STAGES];
   logic [NUM_IN-1:0] active;
   logic [NUM_IN-1:0] hist_new_q;
   logic [NUM_IN-1:0] hist_old_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SYNC_STAGES; s++) begin
            sync_q[s] <= '0;
         end
      end else begin
         sync_q[0] <= gpi_i;
         for (int s = 1; s < SYNC_STAGES; s++) begin
            sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign active = sync_q[LAST] ^ level_inv_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_new_q <= '0;
         hist_old_q <= '0;
      end else if (sample_en_i) begin
         hist_new_q <= active;
         hist_old_q <= hist_new_q;
      end
   end

   // active on two consecutive strobes
   assign qual_o = hist_new_q & hist_old_q;

endmodule

// File: rtl/gpi_status_bank.sv
module gpi_status_bank #(
   parameter int NUM_IN = 16
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_IN-1:0] qual_i,
   input  logic [NUM_IN-1:1] clr_i,
   output logic [NUM_IN-1:0] status_o
);

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
         if (i == 0) begin : g_live
            assign status_o[i] = qual_i[i];
         end else begin : g_sticky
            logic st_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  st_q <= 1'b0;
               end else begin
                  // set wins over a simultaneous clear
                  st_q <= (st_q & ~clr_i[i]) | qual_i[i];
               end
            end
            assign status_o[i] = st_q;
         end
      end
   endgenerate

endmodule

// File: rtl/gpi_irq_router.sv
module gpi_irq_router
   import gpi_evt_pkg::*;
#(
   parameter int NUM_IN = 16,
   localparam int ROUTE_W = 2 * NUM_IN
)(
   input  logic [ROUTE_W-1:0] route_i,
   input  logic [NUM_IN-1:0]  status_i,
   output logic               irq_mgmt_o,
   output logic               irq_cfg_o
);

   logic [NUM_IN-1:0] hit_mgmt;
   logic [NUM_IN-1:0] hit_cfg;

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_route
         route_e sel;
         assign sel         = route_e'(route_i[2*i +: 2]);
         assign hit_mgmt[i] = status_i[i] && (sel == ROUTE_MGMT);
         assign hit_cfg[i]  = status_i[i] && (sel == ROUTE_CFG);
      end
   endgenerate

   assign irq_mgmt_o = |hit_mgmt;
   assign irq_cfg_o  = |hit_cfg;

endmodule

// File: rtl/gpi_event_router.sv
module gpi_event_router
   import gpi_evt_pkg::*;
#(
   parameter int NUM_IN      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FAST_DIV    = 1,
   localparam int REG_W      = 2 * NUM_IN
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sleep_i,
   input  logic              slow_tick_i,
   input  logic [NUM_IN-1:0] gpi_i,
   input  logic [1:0]        reg_addr_i,
   input  logic              reg_we_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              irq_mgmt_o,
   output logic              irq_cfg_o
);

   generate
      if (NUM_IN < 2 || NUM_IN > 32) begin : g_bad_width
         $error("gpi_event_router: NUM_IN must lie in 2..32");
      end
   endgenerate

   logic [NUM_IN-1:0] level_q;
   logic [REG_W-1:0]  route_q;
   logic              sample_en;
   logic [NUM_IN-1:0] qual;
   logic [NUM_IN-1:0] status_view;
   logic [NUM_IN-1:1] clr_mask;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         level_q <= '0;
         route_q <= '0;
      end else if (reg_we_i) begin
         if (reg_addr_i == ADDR_LEVEL) level_q <= reg_wdata_i[NUM_IN-1:0];
         if (reg_addr_i == ADDR_ROUTE) route_q <= reg_wdata_i;
      end
   end

   assign clr_mask = (reg_we_i && reg_addr_i == ADDR_STATUS)
                   ? reg_wdata_i[NUM_IN-1:1] : '0;

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_STATUS: reg_rdata_o[NUM_IN-1:0] = status_view;
         ADDR_LEVEL:  reg_rdata_o[NUM_IN-1:0] = level_q;
         ADDR_ROUTE:  reg_rdata_o             = route_q;
         default:     reg_rdata_o             = '0;
      endcase
   end

   gpi_strobe_gen #(
      .FAST_DIV (FAST_DIV)
   ) u_strobe (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sleep_i     (sleep_i),
      .slow_tick_i (slow_tick_i),
      .sample_en_o (sample_en)
   );

   gpi_input_qual #(
      .NUM_IN      (NUM_IN),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_qual (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .gpi_i       (gpi_i),
      .level_inv_i (level_q),
      .sample_en_i (sample_en),
      .qual_o      (qual)
   );

   gpi_status_bank #(
      .NUM_IN (NUM_IN)
   ) u_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .qual_i   (qual),
      .clr_i    (clr_mask),
      .status_o (status_view)
   );

   gpi_irq_router #(
      .NUM_IN (NUM_IN)
   ) u_router (
      .route_i    (route_q),
      .status_i   (status_view),
      .irq_mgmt_o (irq_mgmt_o),
      .irq_cfg_o  (irq_cfg_o)
   );

endmodule

// File: rtl/gpi_event_router_chk.sv
module gpi_event_router_chk #(
   parameter int NUM_IN = 16
)(
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sleep_i,
   input logic              slow_tick_i,
   input logic [NUM_IN-1:0] qual,
   input logic [NUM_IN-1:0] status_view,
   input logic [NUM_IN-1:1] clr_mask,
   input logic              irq_mgmt_o,
   input logic              irq_cfg_o
);

   // R3
   quiet_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_view == '0) |-> (!irq_mgmt_o && !irq_cfg_o));

   // R11
   sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_i && !slow_tick_i) |=> $stable(qual));

   generate
      for (genvar i = 1; i < NUM_IN; i++) begin : g_bit_chk
         // R4
         set_needs_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(status_view[i]) |-> $past(qual[i]));

         // R5
         sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_view[i] && !clr_mask[i]) |=> status_view[i]);

         // R7
         set_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            qual[i] |=> status_view[i]);
      end
   endgenerate

endmodule

bind gpi_event_router gpi_event_router_chk #(
   .NUM_IN (NUM_IN)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sleep_i     (sleep_i),
   .slow_tick_i (slow_tick_i),
   .qual        (qual),
   .status_view (status_view),
   .clr_mask    (clr_mask),
   .irq_mgmt_o  (irq_mgmt_o),
   .irq_cfg_o   (irq_cfg_o)
);

// File: tb/gpi_event_router_tb.sv
module gpi_event_router_tb;

   localparam int N   = 16;
   localparam int W   = 2 * N;
   localparam int K_MGMT = 0;
   localparam int K_CFG  = 1;
   localparam int K_RD   = 2;

   typedef struct {
      int          due;
      int          kind;
      logic [W-1:0] exp;
      string       tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sleep = 1'b0;
   logic         slow_tick = 1'b0;
   logic         tick_en = 1'b0;
   logic [N-1:0] gpi = '0;
   logic [1:0]   reg_addr = 2'd0;
   logic         reg_we = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         irq_mgmt;
   logic         irq_cfg;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   item_t sb[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   gpi_event_router #(.NUM_IN(N)) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .sleep_i     (sleep),
      .slow_tick_i (slow_tick),
      .gpi_i       (gpi),
      .reg_addr_i  (reg_addr),
      .reg_we_i    (reg_we),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_mgmt_o  (irq_mgmt),
      .irq_cfg_o   (irq_cfg)
   );

   // slow sampling tick: one cycle high every 16 cycles
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         slow_tick = tick_en && (cnt == 15);
         cnt = (cnt + 1) % 16;
      end
   end

   // monitor: compare queued expectations in their due cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         for (int k = sb.size() - 1; k >= 0; k--) begin
            if (sb[k].due <= cyc) begin
               logic [W-1:0] act;
               case (sb[k].kind)
                  K_MGMT:  act = W'(irq_mgmt);
                  K_CFG:   act = W'(irq_cfg);
                  default: act = reg_rdata;
               endcase
               n_chk++;
               if (act !== sb[k].exp || sb[k].due != cyc) begin
                  n_fail++;
                  $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                           sb[k].tag, sb[k].kind, cyc, act, sb[k].exp);
               end
               sb.delete(k);
            end
         end
      end
   end

   task automatic push(input int d, input int kind, input logic [W-1:0] exp, input string tag);
      item_t it;
      it.due  = cyc + d;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      sb.push_back(it);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      push(0, K_RD, exp, tag);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(2'd0, '0, "R1 status");
      push(0, K_MGMT, '0, "R1 mgmt");
      push(0, K_CFG, '0, "R1 cfg");
      rd_chk(2'd1, '0, "R1 level");
      rd_chk(2'd2, '0, "R1 route");

      // R2 routing: in0 cfg, in3 mgmt, in4 cfg, in7 mgmt, in10 reserved, in11 mgmt
      wr(2'd2, 32'h0070_4242);
      rd_chk(2'd2, 32'h0070_4242, "R2 route readback");

      // R9 latency on input 3
      @(negedge clk);
      gpi[3] = 1'b1;
      push(4, K_MGMT, '0, "R9 early");
      push(5, K_MGMT, 1, "R9 due");
      push(5, K_CFG, '0, "R2 not cfg");
      tick(6);
      rd_chk(2'd0, 32'h0008, "R3 status");

      // R5 sticky after release
      @(negedge clk);
      gpi[3] = 1'b0;
      tick(8);
      rd_chk(2'd0, 32'h0008, "R5 sticky");
      push(0, K_MGMT, 1, "R3 held");

      // R4 single-cycle pulse is ignored
      @(negedge clk);
      gpi[4] = 1'b1;
      @(negedge clk);
      gpi[4] = 1'b0;
      tick(10);
      rd_chk(2'd0, 32'h0008, "R4 one sample");
      push(0, K_CFG, '0, "R4 cfg quiet");

      // R4 two-cycle pulse sets
      @(negedge clk);
      gpi[6] = 1'b1;
      tick(2);
      gpi[6] = 1'b0;
      tick(10);
      rd_chk(2'd0, 32'h0048, "R4 two samples");

      // R6 write-one-to-clear and zero writes
      wr(2'd0, 32'h0008);
      rd_chk(2'd0, 32'h0040, "R6 clear");
      push(0, K_MGMT, '0, "R6 irq drop");
      wr(2'd0, 32'h0000);
      rd_chk(2'd0, 32'h0040, "R6 zero write");
      wr(2'd0, 32'h0040);
      rd_chk(2'd0, 32'h0000, "R6 clear all");

      // R7 clear while still active
      @(negedge clk);
      gpi[7] = 1'b1;
      tick(8);
      rd_chk(2'd0, 32'h0080, "R7 set");
      wr(2'd0, 32'h0080);
      push(0, K_RD, 32'h0080, "R7 set wins");
      push(0, K_MGMT, 1, "R7 irq kept");
      tick(3);
      rd_chk(2'd0, 32'h0080, "R7 still set");
      @(negedge clk);
      gpi[7] = 1'b0;
      tick(8);
      wr(2'd0, 32'h0080);
      rd_chk(2'd0, 32'h0000, "R7 cleared");

      // R8 active-low polarity on input 9 with pin low
      wr(2'd1, 32'h0200);
      reg_addr = 2'd0;
      push(2, K_RD, 32'h0000, "R8 early");
      push(3, K_RD, 32'h0200, "R8 due");
      tick(5);
      rd_chk(2'd1, 32'h0200, "R8 level readback");
      wr(2'd1, 32'h0000);
      tick(6);
      wr(2'd0, 32'h0200);
      rd_chk(2'd0, 32'h0000, "R8 restore");

      // R10 input 0 live level
      @(negedge clk);
      gpi[0] = 1'b1;
      push(3, K_CFG, '0, "R10 rise early");
      push(4, K_CFG, 1, "R10 rise due");
      tick(5);
      wr(2'd0, 32'h0001);
      rd_chk(2'd0, 32'h0001, "R10 clear ignored");
      @(negedge clk);
      gpi[0] = 1'b0;
      push(2, K_CFG, 1, "R10 fall early");
      push(3, K_CFG, '0, "R10 fall due");
      tick(4);
      rd_chk(2'd0, 32'h0000, "R10 follows");

      // R2 reserved code routes nowhere
      @(negedge clk);
      gpi[10] = 1'b1;
      tick(8);
      rd_chk(2'd0, 32'h0400, "R2 reserved status");
      push(0, K_MGMT, '0, "R2 reserved mgmt");
      push(0, K_CFG, '0, "R2 reserved cfg");
      @(negedge clk);
      gpi[10] = 1'b0;
      tick(6);
      wr(2'd0, 32'h0400);

      // R11 slow sampling while asleep
      @(negedge clk);
      sleep   = 1'b1;
      tick_en = 1'b1;
      tick(20);
      gpi[11] = 1'b1;
      tick(5);
      gpi[11] = 1'b0;
      tick(40);
      rd_chk(2'd0, 32'h0000, "R11 short pulse");
      push(0, K_MGMT, '0, "R11 mgmt quiet");
      @(negedge clk);
      gpi[11] = 1'b1;
      tick(60);
      rd_chk(2'd0, 32'h0800, "R11 long hold");
      push(0, K_MGMT, 1, "R11 mgmt");
      @(negedge clk);
      gpi[11] = 1'b0;
      tick(40);
      sleep   = 1'b0;
      tick_en = 1'b0;
      wr(2'd0, 32'h0800);
      rd_chk(2'd0, 32'h0000, "R11 cleared");

      tick(3);
      done = 1'b1;
      finish_run();
   end

endmodule